// File: doc/BRIEF.md
# Bridge Overcurrent Fault Supervisor

This block supervises the power stages of a multi-bridge motor driver. Each H-bridge reports a raw overcurrent flag from its output FETs. A per-bridge controller filters that flag with a deglitch window. The window is shorter when the bridge is commanded to a low current level and longer at a high level. Once the flag has been seen for the whole window, only that bridge is switched off. After a fixed hold-off period the bridge is switched back on, and the cycle repeats for as long as the overcurrent persists.

Chip-wide conditions act on every bridge at once. An over-temperature flag switches all bridges off for as long as it is present, with no timed retry. An undervoltage flag or a sleep request switches everything off and also clears every per-bridge controller. A supply-not-ready indication, seen at power-up or after a wake, keeps the bridges off without clearing anything. All sources are merged into one active-low fault output. All inputs are assumed to be synchronous to `clk`. The outputs are combinational from registered controller state and these inputs.

Top module: `ovc_fault_supervisor`

## Requirements
- R1: An overcurrent flag sampled high on fewer consecutive clock edges than the active deglitch length has no effect on the enables or the fault output. A single low sample restarts the count from zero.
- R2: Bit i of `lvl_hi_i` selects the deglitch length for bridge i: `DGL_HI_CYC` edges when the bit is 1 and `DGL_LO_CYC` edges when it is 0. The bridge trips on the edge that completes the window.
- R3: A trip drives the tripping bridge's bit of `bridge_en_o` to 0 and drives `fault_n_o` to 0. The other bridges' enables are unaffected.
- R4: A tripped bridge stays off for exactly `RETRY_CYC` clock cycles. It is then re-enabled, and the fault is released unless another source is active.
- R5: The overcurrent flag is ignored during the hold-off. If the flag is still high after re-enable, a fresh deglitch window starts and the bridge trips again.
- R6: While `ot_i` is 1, all enables are 0 and `fault_n_o` is 0. Both recover in the cycle `ot_i` clears.
- R7: While `uv_i` is 1, all enables are 0 and `fault_n_o` is 0. Every clock edge with `uv_i` high returns all controllers to the running state, ending any hold-off.
- R8: `sleep_i` acts like `uv_i`: outputs off, fault low, controllers cleared.
- R9: While `supply_rdy_i` is 0, all enables are 0 and `fault_n_o` is 0. Controller state, including a hold-off in progress, is preserved.
- R10: `fault_n_o` is 0 exactly when any source is active: a bridge in hold-off, `uv_i`, `ot_i`, `sleep_i`, or `supply_rdy_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ocp_raw_i | input | NUM_BRIDGES | Raw overcurrent flag per bridge |
| lvl_hi_i | input | NUM_BRIDGES | Commanded current is high (selects the long deglitch) |
| uv_i | input | 1 | Supply undervoltage |
| ot_i | input | 1 | Die over-temperature |
| sleep_i | input | 1 | Sleep request |
| supply_rdy_i | input | 1 | Internal supplies stable |
| bridge_en_o | output | NUM_BRIDGES | Per-bridge output-stage enable |
| fault_n_o | output | 1 | Active-low merged fault |

## Verification
Two events can land on the same clock edge: one bridge's hold-off expiry and another bridge's deglitch trip. If that happens, the fault output must stay low across the handover, with no one-cycle release. The bench starts bridge 1's overcurrent so that its short window completes on the exact edge where bridge 0's hold-off ends. It then checks, just after that edge, that bridge 0 is enabled, bridge 1 is off and the fault is still low.

// File: rtl/ovc_pkg.sv
`timescale 1ns/1ps
package ovc_pkg;
   typedef enum logic {
      BR_RUN     = 1'b0,
      BR_HOLDOFF = 1'b1
   } br_state_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ovc_bridge_ctl.sv
`timescale 1ns/1ps
module ovc_bridge_ctl
   import ovc_pkg::*;
#(
   parameter int unsigned DGL_HI_CYC = 160,
   parameter int unsigned DGL_LO_CYC = 110,
   parameter int unsigned RETRY_CYC  = 120000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic ocp_i,
   input  logic lvl_hi_i,
   output logic off_o
);
   localparam int unsigned MAXV = max_u(DGL_HI_CYC, RETRY_CYC);
   localparam int unsigned CW   = $clog2(MAXV + 1);
   localparam logic [CW-1:0] LIM_HI = CW'(DGL_HI_CYC - 1);
   localparam logic [CW-1:0] LIM_LO = CW'(DGL_LO_CYC - 1);
   localparam logic [CW-1:0] LIM_RT = CW'(RETRY_CYC - 1);

   br_state_e     st_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   always_comb lim = lvl_hi_i ? LIM_HI : LIM_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BR_RUN;
         cnt_q <= '0;
      end else if (clr_i) begin
         st_q  <= BR_RUN;
         cnt_q <= '0;
      end else begin
         case (st_q)
            BR_RUN: begin
               if (!ocp_i) begin
                  cnt_q <= '0;
               end else if (cnt_q >= lim) begin
                  st_q  <= BR_HOLDOFF;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: begin
               if (cnt_q == LIM_RT) begin
                  st_q  <= BR_RUN;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
         endcase
      end
   end

   assign off_o = (st_q == BR_HOLDOFF);

   // R1: a low sample keeps the bridge running with an empty count
   a_r1_low_restarts: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
      (st_q == BR_RUN && !ocp_i) |=> (st_q == BR_RUN && cnt_q == '0));

   // R2: no trip before the shorter window has been counted
   a_r2_no_early_trip: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
      (st_q == BR_RUN && cnt_q < LIM_LO) |=> (st_q == BR_RUN));

   // R4: hold-off is not cut short
   a_r4_holdoff_kept: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
      (st_q == BR_HOLDOFF && cnt_q != LIM_RT) |=> (st_q == BR_HOLDOFF));

   // R7: a clear edge leaves the controller running and empty
   a_r7_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i) |-> (st_q == BR_RUN && cnt_q == '0));
endmodule

// File: rtl/ovc_fault_merge.sv
`timescale 1ns/1ps
module ovc_fault_merge #(
   parameter int unsigned NUM_BRIDGES = 2
) (
   input  logic [NUM_BRIDGES-1:0] oc_off_i,
   input  logic                   uv_i,
   input  logic                   ot_i,
   input  logic                   sleep_i,
   input  logic                   supply_rdy_i,
   output logic [NUM_BRIDGES-1:0] bridge_en_o,
   output logic                   fault_n_o
);
   logic chip_off;

   always_comb begin
      chip_off    = uv_i | ot_i | sleep_i | ~supply_rdy_i;
      bridge_en_o = ~oc_off_i & {NUM_BRIDGES{~chip_off}};
      fault_n_o   = ~((|oc_off_i) | chip_off);
   end
endmodule

// File: rtl/ovc_fault_supervisor.sv
`timescale 1ns/1ps
module ovc_fault_supervisor #(
   parameter int unsigned NUM_BRIDGES = 2,
   parameter int unsigned DGL_HI_CYC  = 160,
   parameter int unsigned DGL_LO_CYC  = 110,
   parameter int unsigned RETRY_CYC   = 120000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_BRIDGES-1:0] ocp_raw_i,
   input  logic [NUM_BRIDGES-1:0] lvl_hi_i,
   input  logic                   uv_i,
   input  logic                   ot_i,
   input  logic                   sleep_i,
   input  logic                   supply_rdy_i,
   output logic [NUM_BRIDGES-1:0] bridge_en_o,
   output logic                   fault_n_o
);
   if (NUM_BRIDGES < 1) begin : g_bad_nb
      $error("NUM_BRIDGES must be at least 1");
   end
   if (DGL_LO_CYC < 1 || DGL_LO_CYC > DGL_HI_CYC) begin : g_bad_dgl
      $error("deglitch lengths must satisfy 1 <= DGL_LO_CYC <= DGL_HI_CYC");
   end
   if (RETRY_CYC < 2) begin : g_bad_rt
      $error("RETRY_CYC must be at least 2");
   end

   logic                   clr;
   logic [NUM_BRIDGES-1:0] oc_off;

   assign clr = uv_i | sleep_i;

   for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
      ovc_bridge_ctl #(
         .DGL_HI_CYC (DGL_HI_CYC),
         .DGL_LO_CYC (DGL_LO_CYC),
         .RETRY_CYC  (RETRY_CYC)
      ) u_ctl (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_i    (clr),
         .ocp_i    (ocp_raw_i[b]),
         .lvl_hi_i (lvl_hi_i[b]),
         .off_o    (oc_off[b])
      );
   end

   ovc_fault_merge #(.NUM_BRIDGES(NUM_BRIDGES)) u_merge (
      .oc_off_i     (oc_off),
      .uv_i         (uv_i),
      .ot_i         (ot_i),
      .sleep_i      (sleep_i),
      .supply_rdy_i (supply_rdy_i),
      .bridge_en_o  (bridge_en_o),
      .fault_n_o    (fault_n_o)
   );

   // R3: any bridge in hold-off pulls the fault low and is disabled
   a_r3_holdoff_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (|oc_off) |-> (!fault_n_o && ((bridge_en_o & oc_off) == '0)));

   // R6: over-temperature blanks every bridge
   a_r6_ot_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      ot_i |-> (bridge_en_o == '0 && !fault_n_o));

   // R10: a released fault means no source is active
   a_r10_released_clean: assert property (@(posedge clk) disable iff (!rst_n)
      fault_n_o |-> (!uv_i && !ot_i && !sleep_i && supply_rdy_i && oc_off == '0));
endmodule

// File: tb/ovc_fault_supervisor_bench.sv
`timescale 1ns/1ps
module ovc_fault_supervisor_bench;
   localparam int unsigned NB  = 2;
   localparam int unsigned DHI = 6;
   localparam int unsigned DLO = 3;
   localparam int unsigned RT  = 12;

   // columns: samples high, level bit, trip expected
   localparam int unsigned VEC [8][3] = '{
      '{2, 1, 0}, '{5, 1, 0}, '{6, 1, 1}, '{7, 1, 1},
      '{2, 0, 0}, '{3, 0, 1}, '{4, 0, 1}, '{5, 0, 1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] ocp = '0;
   logic [NB-1:0] lvl = '1;
   logic          uv = 1'b0, ot = 1'b0, slp = 1'b0, rdy = 1'b1;
   logic [NB-1:0] en;
   logic          fault_n;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   ovc_fault_supervisor #(
      .NUM_BRIDGES(NB), .DGL_HI_CYC(DHI), .DGL_LO_CYC(DLO), .RETRY_CYC(RT)
   ) u_ovc_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .ocp_raw_i(ocp), .lvl_hi_i(lvl),
      .uv_i(uv), .ot_i(ot), .sleep_i(slp), .supply_rdy_i(rdy),
      .bridge_en_o(en), .fault_n_o(fault_n)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk(en[0], 1'b1, "reset R3 en0");
      chk(en[1], 1'b1, "reset R3 en1");
      chk(fault_n, 1'b1, "reset R10 fault_n");

      // table: R1 / R2 / R3 / R4 on bridge 0
      for (int r = 0; r < 8; r++) begin
         lvl[0] = VEC[r][1][0];
         ocp[0] = 1'b1;
         tick(int'(VEC[r][0]));
         chk(en[0], !VEC[r][2][0], $sformatf("R2 row %0d en0", r));
         chk(fault_n, !VEC[r][2][0], $sformatf("R1 row %0d fault_n", r));
         chk(en[1], 1'b1, $sformatf("R3 row %0d en1", r));
         ocp[0] = 1'b0;
         tick(RT + 2);
         chk(en[0], 1'b1, $sformatf("R4 row %0d recovered", r));
      end

      // R1: a one-cycle gap restarts the window
      lvl[0] = 1'b1;
      ocp[0] = 1'b1; tick(5);
      ocp[0] = 1'b0; tick(1);
      ocp[0] = 1'b1; tick(5);
      chk(en[0], 1'b1, "R1 gap restarts count");
      ocp[0] = 1'b0; tick(1);

      // R4: exact hold-off length
      ocp[0] = 1'b1; tick(DHI);
      chk(en[0], 1'b0, "R4 tripped");
      ocp[0] = 1'b0; tick(RT - 1);
      chk(en[0], 1'b0, "R4 still off last cycle");
      tick(1);
      chk(en[0], 1'b1, "R4 back on");
      chk(fault_n, 1'b1, "R4 fault released");

      // R5: persistent overcurrent retrips
      ocp[0] = 1'b1; tick(DHI);
      chk(en[0], 1'b0, "R5 first trip");
      tick(RT);
      chk(en[0], 1'b1, "R5 retry enable");
      tick(DHI - 1);
      chk(en[0], 1'b1, "R5 fresh window not done");
      tick(1);
      chk(en[0], 1'b0, "R5 retrip");
      ocp[0] = 1'b0; tick(RT + 2);

      // R10 / R3: bridge 0 retry expiry coincides with bridge 1 trip
      ocp[0] = 1'b1; tick(DHI);
      ocp[0] = 1'b0;
      tick(RT - DLO);
      lvl[1] = 1'b0; ocp[1] = 1'b1;
      tick(DLO);
      chk(en[0], 1'b1, "R4 coincide en0 back");
      chk(en[1], 1'b0, "R3 coincide en1 off");
      chk(fault_n, 1'b0, "R10 coincide fault held");
      ocp[1] = 1'b0; tick(RT + 2); lvl[1] = 1'b1;

      // R6: over-temperature
      ot = 1'b1; tick(1);
      chk(en[0] | en[1], 1'b0, "R6 ot blanks");
      chk(fault_n, 1'b0, "R6 ot fault");
      ot = 1'b0; tick(1);
      chk(en[0] & en[1], 1'b1, "R6 ot recovery");
      chk(fault_n, 1'b1, "R6 ot fault release");

      // R7: undervoltage clears a hold-off
      lvl[0] = 1'b0; ocp[0] = 1'b1; tick(DLO);
      chk(en[0], 1'b0, "R7 pre-trip");
      ocp[0] = 1'b0; uv = 1'b1; tick(1);
      chk(fault_n, 1'b0, "R7 uv fault");
      chk(en[1], 1'b0, "R7 uv blanks");
      uv = 1'b0; tick(1);
      chk(en[0], 1'b1, "R7 hold-off cleared");
      chk(fault_n, 1'b1, "R7 fault released");

      // R8: sleep clears a hold-off
      lvl[1] = 1'b0; ocp[1] = 1'b1; tick(DLO);
      chk(en[1], 1'b0, "R8 pre-trip");
      ocp[1] = 1'b0; slp = 1'b1; tick(1);
      chk(fault_n, 1'b0, "R8 sleep fault");
      slp = 1'b0; tick(1);
      chk(en[1], 1'b1, "R8 hold-off cleared");

      // R9: supply not ready keeps state
      ocp[1] = 1'b1; tick(DLO);
      ocp[1] = 1'b0; rdy = 1'b0; tick(1);
      chk(fault_n, 1'b0, "R9 not ready fault");
      chk(en[0], 1'b0, "R9 not ready blanks");
      rdy = 1'b1; tick(1);
      chk(en[1], 1'b0, "R9 hold-off kept");
      chk(en[0], 1'b1, "R9 other bridge back");
      chk(fault_n, 1'b0, "R10 hold-off still faults");
      tick(RT);
      chk(en[1], 1'b1, "R9 hold-off completes");
      chk(fault_n, 1'b1, "R10 all clear");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule